// File: doc/BRIEF.md
# Multi-mode reloading interval timer

This block is an 8-bit interval timer for a peripheral controller. Software programs a reload value and a mode. The block then counts down on qualifying pulses. When the count reaches zero it reloads itself, toggles a square-wave output and, if enabled, raises a one-cycle interrupt request.

A qualifying pulse comes from one of three sources:
- a prescaled system clock, with a divide ratio of 4, 10, 16, 50, 64, 100 or 200;
- rising edges of an external input;
- the prescaled clock passed through only while the external input, used as a gate, is high.

A small control state machine follows the mode code. Its states are OFF (stopped), DELAY (prescaled clock), EVENT (external edges) and GATED (prescaled clock qualified by the gate). Every control-register write is a transition. The machine goes to OFF on code 0, to DELAY on codes 1 to 7, to EVENT on code 8 and to GATED on codes 9 to 15. Without a control write, every state holds itself.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the counter, the reload value, the mode code and the interrupt enable are all 0, and irq and tout are low.
- R2: With mode code 0 the counter never changes except by writes. A data write (addr=1) while stopped loads both the reload value and the counter.
- R3: Mode codes 1 to 7 decrement the counter once every D clocks, with D = 4, 10, 16, 50, 64, 100, 200 for codes 1 to 7 in that order. The prescaler restarts on any change of mode code, so with counter value N the first zero comes exactly N*D clocks after the control write edge.
- R4: On the step that takes the counter from 1 to 0, the counter loads the reload value instead, tout toggles, and irq is high for exactly one clock if enabled.
- R5: The interrupt enable is control bit 5. With it clear, irq stays low while tout still toggles and reloads still happen.
- R6: Mode code 8 decrements the counter once per rising edge of ext_in, three clocks after the edge (two synchronizer flops plus an edge register). A steady level produces no counts.
- R7: Mode codes 9 to 15 use the same seven ratios as codes 1 to 7, taken from the low three bits. Counts happen only while the synchronized ext_in is high; with ext_in low the counter holds.
- R8: A control write with bit 4 set loads the counter from the reload value, clears tout and restarts the prescaler. Bit 4 is not stored and always reads 0.
- R9: A data write while the timer runs changes only the reload value. The counter continues from its value and takes the new reload at the next zero.
- R10: Reading with addr=1 returns the live counter. Reading with addr=0 returns the control register: mode in bits 3:0, enable in bit 5, and the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the control register, 1 selects the data register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data; combinational from addr |
| ext_in | input | 1 | External event / gate input, asynchronous |
| irq | output | 1 | One-cycle interrupt request on zero |
| tout | output | 1 | Output that toggles on every zero |

## Verification
All seven delay codes and all seven gated codes are swept with the gate held high. In each case the bench measures the clocks from the mode write to the first and the second interrupt and compares them with N times the ratio. This tells the ratios apart and shows whether the prescaler restarts cleanly. Gated mode with the gate held low must produce no counts.

Event mode is driven with isolated pulses, and with a level held high, to separate edge counting from level counting. Separate runs cover the following:
- a data write in mid-count, to separate the live counter from the reload value;
- a forced reset in mid-count, to confirm that the prescaler phase is lost;
- interrupts disabled, to separate irq from tout.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int RATIO_W = 8;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_DELAY,
        ST_EVENT,
        ST_GATED
    } tmr_state_e;

    // Mode code to controller state: 0 off, 1-7 delay, 8 event, 9-15 gated
    function automatic tmr_state_e state_of(input logic [3:0] code);
        tmr_state_e s;
        if (code == 4'd0)      s = ST_OFF;
        else if (code == 4'd8) s = ST_EVENT;
        else if (code[3])      s = ST_GATED;
        else                   s = ST_DELAY;
        return s;
    endfunction

    // Low three mode bits select the prescale ratio
    function automatic logic [RATIO_W-1:0] ratio_of(input logic [2:0] sel);
        logic [RATIO_W-1:0] r;
        unique case (sel)
            3'd1:    r = 8'd4;
            3'd2:    r = 8'd10;
            3'd3:    r = 8'd16;
            3'd4:    r = 8'd50;
            3'd5:    r = 8'd64;
            3'd6:    r = 8'd100;
            3'd7:    r = 8'd200;
            default: r = 8'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic            restart_i,
    input  logic [PS_W-1:0] ratio_i,
    output logic            tick_o
);

    logic [PS_W-1:0] pc_q;

    assign tick_o = run_i && (pc_q == ratio_i - PS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (restart_i) begin
            pc_q <= '0;
        end else if (run_i) begin
            if (tick_o) pc_q <= '0;
            else        pc_q <= pc_q + PS_W'(1);
        end
    end

    // R3: phase counter stays inside the selected ratio
    p_presc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (pc_q < ratio_i));

endmodule

// File: rtl/ivl_sync_edge.sv
module ivl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~prev_q;

    // R6: one edge yields one count pulse
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/ivl_downcnt.sv
module ivl_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         step_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);

    logic [W-1:0] cnt_q;

    assign wrap_o = step_i && !ld_i && (cnt_q == W'(1));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_i) begin
            cnt_q <= ld_val_i;
        end else if (step_i) begin
            if (cnt_q == W'(1)) cnt_q <= reload_i;
            else                cnt_q <= cnt_q - W'(1);
        end
    end

    // R3: without a load the counter holds, steps by one, or reloads
    p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - W'(1)
                   || cnt_q == $past(reload_i)));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             ext_in,
    output logic             irq,
    output logic             tout
);

    localparam int PS_W    = RATIO_W;
    localparam int BIT_FRC = 4;
    localparam int BIT_IEN = 5;

    tmr_state_e       st_q, st_d;
    logic [3:0]       mode_q;
    logic             ien_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ctl_rd;
    logic [CNT_W-1:0] ld_val;
    logic             wr_ctl, wr_dat, frc, restart, ld;
    logic             run_ps, tick, step, wrap;
    logic             gate, rise;

    assign wr_ctl  = wr_en && !addr;
    assign wr_dat  = wr_en && addr;
    assign frc     = wr_ctl && wdata[BIT_FRC];
    assign restart = wr_ctl && ((wdata[3:0] != mode_q) || wdata[BIT_FRC]);
    assign ld      = (wr_dat && (st_q == ST_OFF)) || frc;
    assign ld_val  = wr_dat ? wdata : reload_q;

    // Controller state: every control write is a transition
    assign st_d = wr_ctl ? state_of(wdata[3:0]) : st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Per-state pulse qualification
    always_comb begin
        run_ps = 1'b0;
        step   = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                run_ps = 1'b0;
                step   = 1'b0;
            end
            ST_DELAY: begin
                run_ps = 1'b1;
                step   = tick;
            end
            ST_EVENT: begin
                run_ps = 1'b0;
                step   = rise;
            end
            ST_GATED: begin
                run_ps = 1'b1;
                step   = tick && gate;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ien_q    <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_ctl) begin
                mode_q <= wdata[3:0];
                ien_q  <= wdata[BIT_IEN];
            end
            if (wr_dat) reload_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            tout <= 1'b0;
        end else if (frc) begin
            irq  <= 1'b0;
            tout <= 1'b0;
        end else if (wrap) begin
            irq  <= ien_q;
            tout <= ~tout;
        end else begin
            irq  <= 1'b0;
        end
    end

    always_comb begin
        ctl_rd          = '0;
        ctl_rd[3:0]     = mode_q;
        ctl_rd[BIT_IEN] = ien_q;
        rdata           = addr ? cnt : ctl_rd;
    end

    ivl_prescaler #(.PS_W(PS_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_ps),
        .restart_i (restart),
        .ratio_i   (ratio_of(mode_q[2:0])),
        .tick_o    (tick)
    );

    ivl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in),
        .level_o (gate),
        .rise_o  (rise)
    );

    ivl_downcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (ld),
        .ld_val_i (ld_val),
        .step_i   (step),
        .reload_i (reload_q),
        .cnt_o    (cnt),
        .wrap_o   (wrap)
    );

    // R4: interrupt request lasts one clock
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: every interrupt coincides with a tout toggle
    p_tout_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tout != $past(tout)));

    // R5: no request unless enabled
    p_irq_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ien_q));

    // R2: stopped timer holds its count
    p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !wr_en) |=> $stable(cnt));

    // R8: forced reset reloads and clears the toggle output
    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[BIT_FRC]) |=> (cnt == $past(reload_q) && !tout));

endmodule

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       irq;
    logic       tout;

    int checks = 0;
    int fails = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

    ivl_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_in(ext_in), .irq(irq), .tout(tout)
    );

    function automatic int bdiv(input int sel);
        case (sel)
            1: return 4;  2: return 10; 3: return 16; 4: return 50;
            5: return 64; 6: return 100; default: return 200;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic measure(input int lim, output int k);
        k = 0;
        while (!irq && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Sweep one code: two full periods with reload 3
    task automatic sweep(input int code, input string tag);
        int k, v, t1, d;
        d = bdiv(code & 7);
        wr(0, 8'h20);
        wr(1, 3);
        wr(0, 8'h20 | code);
        measure(3000, k);
        chk(tag, k, 3 * d);
        rd(1, v);
        chk("R4 reload", v, 3);
        t1 = int'(tout);
        @(negedge clk);
        chk("R4 irq one cycle", int'(irq), 0);
        measure(3000, k);
        chk(tag, k + 1, 3 * d);
        chk("R4 tout toggle", int'(tout), 1 - t1);
    endtask

    initial begin
        int v, k, ic0, t0, v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 ctl", v, 0);
        rd(1, v); chk("R1 cnt", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tout", int'(tout), 0);

        // R2 stopped: data write loads counter, counter holds
        wr(1, 7);
        rd(1, v); chk("R2 load", v, 7);
        repeat (50) @(negedge clk);
        rd(1, v); chk("R2 hold", v, 7);

        // R10 control readback
        wr(0, 8'h2C);
        rd(0, v); chk("R10 ctl read", v, 8'h2C);
        wr(0, 8'h00);

        // R3 delay sweep
        for (int c = 1; c <= 7; c++) sweep(c, "R3 delay period");

        // R7 gated sweep, gate high
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        for (int c = 9; c <= 15; c++) sweep(c, "R7 gated period");

        // R7 gate low: no counting
        ext_in = 1'b0;
        wr(0, 8'h20);
        wr(1, 3);
        repeat (4) @(negedge clk);
        wr(0, 8'h29);
        ic0 = irq_cnt;
        repeat (300) @(negedge clk);
        rd(1, v); chk("R7 gate low hold", v, 3);
        chk("R7 gate low irq", irq_cnt - ic0, 0);
        ext_in = 1'b1;
        measure(40, k);
        chk("R7 gate open irq", int'(irq), 1);
        ext_in = 1'b0;

        // R6 event counting
        wr(0, 8'h20);
        wr(1, 5);
        repeat (4) @(negedge clk);
        wr(0, 8'h28);
        ic0 = irq_cnt;
        for (int i = 1; i <= 5; i++) begin
            ext_in = 1'b1;
            repeat (4) @(negedge clk);
            rd(1, v); chk("R6 edge count", v, (i < 5) ? 5 - i : 5);
            ext_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        chk("R6 irq on zero", irq_cnt - ic0, 1);
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(1, v0);
        repeat (20) @(negedge clk);
        rd(1, v); chk("R6 level no count", v, v0);
        chk("R6 one edge", v0, 4);
        ext_in = 1'b0;

        // R5 interrupts disabled
        wr(0, 8'h00);
        wr(1, 2);
        wr(0, 8'h01);
        t0 = int'(tout);
        ic0 = irq_cnt;
        repeat (8) @(negedge clk);
        chk("R5 tout toggles", int'(tout), 1 - t0);
        chk("R5 irq low", int'(irq), 0);
        rd(1, v); chk("R5 reload", v, 2);
        repeat (4) @(negedge clk);
        chk("R5 no irq", irq_cnt - ic0, 0);

        // R8 forced reset
        wr(0, 8'h20);
        wr(1, 10);
        wr(0, 8'h21);
        repeat (13) @(negedge clk);
        rd(1, v); chk("R3 mid count", v, 7);
        wr(0, 8'h31);
        rd(1, v); chk("R8 counter reload", v, 10);
        chk("R8 tout cleared", int'(tout), 0);
        rd(0, v); chk("R8 bit4 not stored", v, 8'h21);
        measure(200, k);
        chk("R8 prescaler restart", k, 40);

        // R9 data write while running
        wr(0, 8'h20);
        wr(1, 6);
        wr(0, 8'h21);
        wr(1, 3);
        rd(1, v); chk("R9 count unaffected", v, 6);
        measure(200, k);
        chk("R9 old period", k + 2, 24);
        rd(1, v); chk("R9 new reload", v, 3);
        @(negedge clk);
        measure(200, k);
        chk("R9 new period", k + 1, 12);
        wr(0, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule